// File: doc/BRIEF.md
# Device-Paced Peripheral Read Sequencer

This block runs one single-beat read on an external peripheral bus, with the peripheral setting the pace through a ready input. A request carries an address and byte enables. A set of per-bank timing values comes with it: chip-select delay, output-enable delay, minimum wait, ready sampling mode, byte-enable mode, parity enable and hold length. A global timeout switch and timeout length also come with it. All of these values are latched when the request is accepted.

The sequencer drives the address, an active-low last-beat flag, the byte enables, and active-low chip select and output enable. It watches ready only after the minimum wait has passed. It then captures data, error and parity, and releases the bus. After a programmable hold it pulses `rsp_done` with the result. If timeouts are enabled, a peripheral that never answers ends the transfer with a timeout flag.

Cycle numbering in the requirements counts cycle 0 as the first clock cycle after the edge that accepted the request.

Top module: `pbus_read_seq`

## Requirements
- R1: In cycles 0 through the capture cycle, `per_addr` carries the accepted address and `per_last_n` is low. The last flag falls in the very first cycle together with the address.
- R2: When byte-enable mode was set at acceptance, `per_be` (active high, bit i covering data bits 8i+7:8i) shows the accepted byte enables from cycle 0 through capture. When the mode was clear, `per_be` stays all zero.
- R3: `per_cs_n` is low in every active cycle whose index is at least the chip-select delay, and high before that.
- R4: `per_oe_n` is low in every active cycle whose index is at least the chip-select delay plus the output-enable delay, and high before that.
- R5: Ready is ignored in any cycle whose index is below wait+1. The first qualifying cycle is the first cycle with index ≥ wait+1 in which `per_ready` is high.
- R6: With the timeout enabled and no qualifying ready, the transfer ends at the end of cycle max(timeout−1, 0), with `rsp_tmo` set. A ready that qualifies in that same cycle takes priority. With the timeout disabled, the sequencer waits for ready indefinitely.
- R7: With sample-on-ready set, data is captured at the end of the qualifying cycle. With it clear, the bus stays active one more cycle and capture happens at the end of that cycle.
- R8: `per_data` and `per_err` are captured at the same edge. With parity enabled, parity bit i covers byte i with odd parity: the 9 bits must hold an odd number of ones. Any failing byte sets `rsp_par_err`. With parity disabled, `rsp_par_err` is 0.
- R9: From the cycle after capture, `per_cs_n`, `per_oe_n` and `per_last_n` are high, while `per_addr` and `per_be` are zero.
- R10: `rsp_done` is a one-cycle pulse in the (hold+1)-th released cycle. `req_ready` is low from cycle 0 until that pulse and high in the cycle after it. Results stay valid until the next acceptance.
- R11: A timed-out transfer returns `rsp_data` = 0, `rsp_err` = 0, `rsp_par_err` = 0 and `rsp_tmo` = 1. A transfer ended by ready returns `rsp_tmo` = 0.
- R12: Changes on the request and configuration inputs after acceptance have no effect on the running transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Read request |
| req_ready | output | 1 | Sequencer idle, request accepted at this edge |
| req_addr | input | ADDR_W | Read address |
| req_be | input | DATA_W/8 | Byte enables, active high |
| cfg_cs_dly | input | CNT_W | Cycles from address to chip select |
| cfg_oe_dly | input | CNT_W | Cycles from chip select to output enable |
| cfg_wait | input | CNT_W | Minimum wait before ready is watched |
| cfg_sor | input | 1 | Capture in the ready cycle (1) or one cycle later (0) |
| cfg_be_mode | input | 1 | Drive byte enables |
| cfg_par_en | input | 1 | Check parity |
| cfg_hold | input | CNT_W | Released cycles before done |
| cfg_tmo_en | input | 1 | Timeout enable |
| cfg_tmo_cnt | input | TMO_W | Timeout length in cycles |
| per_addr | output | ADDR_W | Peripheral address |
| per_cs_n | output | 1 | Chip select, active low |
| per_oe_n | output | 1 | Output enable, active low |
| per_last_n | output | 1 | Last-beat flag, active low |
| per_be | output | DATA_W/8 | Byte enables, active high |
| per_data | input | DATA_W | Read data bus |
| per_par | input | DATA_W/8 | Per-byte odd parity |
| per_err | input | 1 | Peripheral error |
| per_ready | input | 1 | Peripheral ready |
| rsp_done | output | 1 | End-of-transfer pulse |
| rsp_data | output | DATA_W | Captured data |
| rsp_err | output | 1 | Captured error |
| rsp_par_err | output | 1 | Parity mismatch |
| rsp_tmo | output | 1 | Transfer timed out |

## Verification
The bench drives `per_data`, `per_err` and `per_par` with values that change every cycle. A sequencer that captures one cycle early or late, or that mishandles the extra cycle of the sample-on-ready-off mode, therefore returns the wrong word or the wrong error. Ready is raised before the wait window opens, exactly on the timeout cycle, and one cycle after it. These cases catch an off-by-one window, the wrong priority between ready and timeout, and a timeout of zero. Configuration and request inputs are scrambled right after acceptance, and a chip-select delay longer than the whole transfer is included. A design that reads live configuration, or asserts select too early, shows a wrong strobe on some cycle.

// File: rtl/pbus_rd_pkg.sv
package pbus_rd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_XTRA = 2'd2,
        ST_HOLD = 2'd3
    } rd_state_e;

    // Threshold flags derived from the elapsed-cycle counter.
    typedef struct packed {
        logic cs_on;
        logic oe_on;
        logic win_open;
        logic tmo_hit;
    } phase_t;

    // High when a byte plus its parity bit hold an even number of ones.
    function automatic logic odd_par_bad(input logic [7:0] b, input logic p);
        return ~(^{b, p});
    endfunction

endpackage

// File: rtl/pbus_rd_timer.sv
module pbus_rd_timer
    import pbus_rd_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int TMO_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             run,
    input  logic [CNT_W-1:0] cs_dly,
    input  logic [CNT_W-1:0] oe_dly,
    input  logic [CNT_W-1:0] wait_cnt,
    input  logic [TMO_W-1:0] tmo_cnt,
    output phase_t           ph
);
    localparam int TW = ((TMO_W > CNT_W + 1) ? TMO_W : CNT_W + 1) + 1;

    logic [TW-1:0] elapsed;
    logic [TW:0]   elapsed_nx;

    always_ff @(posedge clk) begin
        if (rst)
            elapsed <= '0;
        else if (clr)
            elapsed <= '0;
        else if (run && (elapsed != {TW{1'b1}}))
            elapsed <= elapsed + 1'b1;
    end

    always_comb begin
        elapsed_nx  = {1'b0, elapsed} + 1'b1;
        ph.cs_on    = elapsed >= TW'(cs_dly);
        ph.oe_on    = elapsed >= (TW'(cs_dly) + TW'(oe_dly));
        ph.win_open = elapsed >= (TW'(wait_cnt) + 1'b1);
        ph.tmo_hit  = elapsed_nx >= (TW+1)'(tmo_cnt);
    end

    // Once the ready window opens it stays open until the next transfer.
    assert_window_sticky_R5: assert property (@(posedge clk) disable iff (rst)
        (ph.win_open && !clr) |=> ph.win_open);

endmodule

// File: rtl/pbus_rd_fsm.sv
module pbus_rd_fsm
    import pbus_rd_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic             ready_in,
    input  logic             sor,
    input  logic             tmo_en,
    input  logic [CNT_W-1:0] hold_cfg,
    input  logic             win_open,
    input  logic             tmo_hit,
    output rd_state_e        state,
    output logic             accept,
    output logic             run,
    output logic             cap_now,
    output logic             cap_tmo,
    output logic             done
);
    rd_state_e        st_q, st_d;
    logic [CNT_W-1:0] hold_q;
    logic             rdy_ok;

    always_comb begin
        accept  = (st_q == ST_IDLE) && req_valid;
        rdy_ok  = (st_q == ST_WAIT) && ready_in && win_open;
        cap_tmo = (st_q == ST_WAIT) && !rdy_ok && tmo_en && tmo_hit;
        cap_now = (rdy_ok && sor) || (st_q == ST_XTRA);
        run     = (st_q == ST_WAIT) || (st_q == ST_XTRA);
        done    = (st_q == ST_HOLD) && (hold_q == '0);
        st_d    = st_q;
        unique case (st_q)
            ST_IDLE: if (accept) st_d = ST_WAIT;
            ST_WAIT: begin
                if (rdy_ok)
                    st_d = sor ? ST_HOLD : ST_XTRA;
                else if (cap_tmo)
                    st_d = ST_HOLD;
            end
            ST_XTRA: st_d = ST_HOLD;
            ST_HOLD: if (hold_q == '0) st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            hold_q <= '0;
        end else begin
            st_q <= st_d;
            if (cap_now || cap_tmo)
                hold_q <= hold_cfg;
            else if ((st_q == ST_HOLD) && (hold_q != '0))
                hold_q <= hold_q - 1'b1;
        end
    end

    assign state = st_q;

    assert_done_single_R10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    assert_idle_after_done_R10: assert property (@(posedge clk) disable iff (rst)
        done |=> (state == ST_IDLE));

endmodule

// File: rtl/pbus_rd_capture.sv
module pbus_rd_capture
    import pbus_rd_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              cap_now,
    input  logic              cap_tmo,
    input  logic              par_en,
    input  logic [DATA_W-1:0] per_data,
    input  logic [DATA_W/8-1:0] per_par,
    input  logic              per_err,
    output logic [DATA_W-1:0] rsp_data,
    output logic              rsp_err,
    output logic              rsp_par_err,
    output logic              rsp_tmo
);
    localparam int NB = DATA_W / 8;

    logic [NB-1:0] byte_bad;

    for (genvar i = 0; i < NB; i++) begin : g_par
        assign byte_bad[i] = odd_par_bad(per_data[8*i +: 8], per_par[i]);
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            rsp_data    <= '0;
            rsp_err     <= 1'b0;
            rsp_par_err <= 1'b0;
            rsp_tmo     <= 1'b0;
        end else if (cap_now) begin
            rsp_data    <= per_data;
            rsp_err     <= per_err;
            rsp_par_err <= par_en && (|byte_bad);
            rsp_tmo     <= 1'b0;
        end else if (cap_tmo) begin
            rsp_data    <= '0;
            rsp_err     <= 1'b0;
            rsp_par_err <= 1'b0;
            rsp_tmo     <= 1'b1;
        end
    end

    // Ready capture and timeout never end the same transfer together.
    assert_cap_exclusive_R6: assert property (@(posedge clk) disable iff (rst)
        !(cap_now && cap_tmo));

endmodule

// File: rtl/pbus_read_seq.sv
module pbus_read_seq
    import pbus_rd_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 8,
    parameter int TMO_W  = 12
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [DATA_W/8-1:0] req_be,
    input  logic [CNT_W-1:0]    cfg_cs_dly,
    input  logic [CNT_W-1:0]    cfg_oe_dly,
    input  logic [CNT_W-1:0]    cfg_wait,
    input  logic                cfg_sor,
    input  logic                cfg_be_mode,
    input  logic                cfg_par_en,
    input  logic [CNT_W-1:0]    cfg_hold,
    input  logic                cfg_tmo_en,
    input  logic [TMO_W-1:0]    cfg_tmo_cnt,
    output logic [ADDR_W-1:0]   per_addr,
    output logic                per_cs_n,
    output logic                per_oe_n,
    output logic                per_last_n,
    output logic [DATA_W/8-1:0] per_be,
    input  logic [DATA_W-1:0]   per_data,
    input  logic [DATA_W/8-1:0] per_par,
    input  logic                per_err,
    input  logic                per_ready,
    output logic                rsp_done,
    output logic [DATA_W-1:0]   rsp_data,
    output logic                rsp_err,
    output logic                rsp_par_err,
    output logic                rsp_tmo
);
    localparam int NB = DATA_W / 8;

    logic [ADDR_W-1:0] addr_q;
    logic [NB-1:0]     be_q;
    logic [CNT_W-1:0]  cs_q, oe_q, wait_q, hold_q;
    logic [TMO_W-1:0]  tmo_cnt_q;
    logic              sor_q, bem_q, par_q, tmo_en_q;

    rd_state_e state;
    phase_t    ph;
    logic      accept, run, cap_now, cap_tmo, drive;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q    <= '0;
            be_q      <= '0;
            cs_q      <= '0;
            oe_q      <= '0;
            wait_q    <= '0;
            hold_q    <= '0;
            tmo_cnt_q <= '0;
            sor_q     <= 1'b0;
            bem_q     <= 1'b0;
            par_q     <= 1'b0;
            tmo_en_q  <= 1'b0;
        end else if (accept) begin
            addr_q    <= req_addr;
            be_q      <= req_be;
            cs_q      <= cfg_cs_dly;
            oe_q      <= cfg_oe_dly;
            wait_q    <= cfg_wait;
            hold_q    <= cfg_hold;
            tmo_cnt_q <= cfg_tmo_cnt;
            sor_q     <= cfg_sor;
            bem_q     <= cfg_be_mode;
            par_q     <= cfg_par_en;
            tmo_en_q  <= cfg_tmo_en;
        end
    end

    pbus_rd_timer #(.CNT_W(CNT_W), .TMO_W(TMO_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .clr      (accept),
        .run      (run),
        .cs_dly   (cs_q),
        .oe_dly   (oe_q),
        .wait_cnt (wait_q),
        .tmo_cnt  (tmo_cnt_q),
        .ph       (ph)
    );

    pbus_rd_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .ready_in  (per_ready),
        .sor       (sor_q),
        .tmo_en    (tmo_en_q),
        .hold_cfg  (hold_q),
        .win_open  (ph.win_open),
        .tmo_hit   (ph.tmo_hit),
        .state     (state),
        .accept    (accept),
        .run       (run),
        .cap_now   (cap_now),
        .cap_tmo   (cap_tmo),
        .done      (rsp_done)
    );

    pbus_rd_capture #(.DATA_W(DATA_W)) u_cap (
        .clk         (clk),
        .rst         (rst),
        .clr         (accept),
        .cap_now     (cap_now),
        .cap_tmo     (cap_tmo),
        .par_en      (par_q),
        .per_data    (per_data),
        .per_par     (per_par),
        .per_err     (per_err),
        .rsp_data    (rsp_data),
        .rsp_err     (rsp_err),
        .rsp_par_err (rsp_par_err),
        .rsp_tmo     (rsp_tmo)
    );

    always_comb begin
        drive      = run;
        req_ready  = (state == ST_IDLE);
        per_addr   = drive ? addr_q : '0;
        per_last_n = !drive;
        per_cs_n   = !(drive && ph.cs_on);
        per_oe_n   = !(drive && ph.oe_on);
        per_be     = (drive && bem_q) ? be_q : '0;
    end

    assert_last_with_addr_R1: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> (!per_last_n && (per_addr == $past(req_addr))));
    assert_oe_inside_cs_R4: assert property (@(posedge clk) disable iff (rst)
        !per_oe_n |-> !per_cs_n);
    assert_released_at_done_R9: assert property (@(posedge clk) disable iff (rst)
        rsp_done |-> (per_cs_n && per_oe_n && per_last_n && (per_be == '0)));
    assert_timeout_result_R11: assert property (@(posedge clk) disable iff (rst)
        (rsp_done && rsp_tmo) |-> ((rsp_data == '0) && !rsp_err && !rsp_par_err));

endmodule

// File: tb/sim_pbus_read_seq.sv
`timescale 1ns/1ps
module sim_pbus_read_seq;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic [3:0]  req_be = '0;
    logic [7:0]  cfg_cs_dly = '0, cfg_oe_dly = '0, cfg_wait = '0, cfg_hold = '0;
    logic        cfg_sor = 1'b0, cfg_be_mode = 1'b0, cfg_par_en = 1'b0, cfg_tmo_en = 1'b0;
    logic [11:0] cfg_tmo_cnt = '0;
    logic [31:0] per_addr;
    logic        per_cs_n, per_oe_n, per_last_n;
    logic [3:0]  per_be;
    logic [31:0] per_data = '0;
    logic [3:0]  per_par = '0;
    logic        per_err = 1'b0, per_ready = 1'b0;
    logic        rsp_done, rsp_err, rsp_par_err, rsp_tmo;
    logic [31:0] rsp_data;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;

    always #5 clk = ~clk;

    pbus_read_seq u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_be(req_be), .cfg_cs_dly(cfg_cs_dly),
        .cfg_oe_dly(cfg_oe_dly), .cfg_wait(cfg_wait), .cfg_sor(cfg_sor),
        .cfg_be_mode(cfg_be_mode), .cfg_par_en(cfg_par_en), .cfg_hold(cfg_hold),
        .cfg_tmo_en(cfg_tmo_en), .cfg_tmo_cnt(cfg_tmo_cnt), .per_addr(per_addr),
        .per_cs_n(per_cs_n), .per_oe_n(per_oe_n), .per_last_n(per_last_n),
        .per_be(per_be), .per_data(per_data), .per_par(per_par), .per_err(per_err),
        .per_ready(per_ready), .rsp_done(rsp_done), .rsp_data(rsp_data),
        .rsp_err(rsp_err), .rsp_par_err(rsp_par_err), .rsp_tmo(rsp_tmo)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    function automatic logic [31:0] dval(input int tid, input int k);
        return 32'hC300_0000 ^ (32'(tid) << 20) ^ (32'(k) << 8) ^ 32'h5A;
    endfunction

    function automatic logic [3:0] goodpar(input logic [31:0] d);
        logic [3:0] p;
        for (int b = 0; b < 4; b++) p[b] = ~(^d[8*b +: 8]);
        return p;
    endfunction

    always @(posedge clk) cyc <= cyc + 1;

    // Reference transaction: expected outputs per cycle computed from the requirements.
    task automatic txn(input int tid, input int cs, input int oe, input int wt,
                       input bit sor, input bit bem, input bit pen, input int hold,
                       input bit ten, input int tcnt, input int rk,
                       input logic [3:0] flip, input bit errv,
                       input logic [31:0] addr, input logic [3:0] be);
        int  q, tmoc, lst, dn;
        bit  rpath;
        logic [31:0] exp_d;
        q     = (rk < 0) ? 1000000 : ((rk > wt + 1) ? rk : wt + 1);
        tmoc  = (tcnt > 0) ? tcnt - 1 : 0;
        rpath = (rk >= 0) && (!ten || (q <= tmoc));
        lst   = rpath ? (q + (sor ? 0 : 1)) : tmoc;
        dn    = lst + 1 + hold;
        exp_d = rpath ? dval(tid, lst) : 32'h0;
        // present the request
        req_valid = 1'b1; req_addr = addr; req_be = be;
        cfg_cs_dly = 8'(cs); cfg_oe_dly = 8'(oe); cfg_wait = 8'(wt); cfg_sor = sor;
        cfg_be_mode = bem; cfg_par_en = pen; cfg_hold = 8'(hold);
        cfg_tmo_en = ten; cfg_tmo_cnt = 12'(tcnt);
        chk("R10 ready before accept", 64'(req_ready), 64'd1);
        @(negedge clk);
        for (int k = 0; k <= dn + 1; k++) begin
            bit act;
            if (k == 0) begin
                // R12: scramble every request and config input after acceptance
                req_valid = 1'b1; req_addr = ~addr; req_be = ~be;
                cfg_cs_dly = 8'(cs + 5); cfg_oe_dly = 8'(oe + 3); cfg_wait = 8'(wt + 7);
                cfg_sor = ~sor; cfg_be_mode = ~bem; cfg_par_en = ~pen;
                cfg_hold = 8'(hold + 4); cfg_tmo_en = ~ten; cfg_tmo_cnt = 12'(tcnt + 9);
            end
            if (k == dn + 1) req_valid = 1'b0;
            act = (k <= lst);
            chk("R1 R12 addr", 64'(per_addr), act ? 64'(addr) : 64'd0);
            chk("R1 R9 last_n", 64'(per_last_n), act ? 64'd0 : 64'd1);
            chk("R2 R9 be", 64'(per_be), (act && bem) ? 64'(be) : 64'd0);
            chk("R3 R9 cs_n", 64'(per_cs_n), (act && k >= cs) ? 64'd0 : 64'd1);
            chk("R4 R9 oe_n", 64'(per_oe_n), (act && k >= cs + oe) ? 64'd0 : 64'd1);
            chk("R10 req_ready", 64'(req_ready), (k > dn) ? 64'd1 : 64'd0);
            chk("R10 done", 64'(rsp_done), (k == dn) ? 64'd1 : 64'd0);
            if (k >= dn) begin
                chk(rpath ? "R8 R7 R5 data" : "R11 R6 data", 64'(rsp_data), 64'(exp_d));
                chk("R8 R11 err", 64'(rsp_err), (rpath && errv) ? 64'd1 : 64'd0);
                chk("R8 R11 par_err", 64'(rsp_par_err),
                    (rpath && pen && flip != 4'd0) ? 64'd1 : 64'd0);
                chk("R6 R11 tmo", 64'(rsp_tmo), rpath ? 64'd0 : 64'd1);
            end
            // peripheral stimulus for cycle k
            per_ready = (rk >= 0) && (k >= rk);
            per_data  = dval(tid, k);
            per_par   = goodpar(dval(tid, k)) ^ flip;
            per_err   = errv ? (k == lst) : (k != lst);
            if (k <= dn) @(negedge clk);
        end
        per_ready = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R10 reset req_ready", 64'(req_ready), 64'd1);
        chk("R9 reset cs_n", 64'(per_cs_n), 64'd1);
        chk("R9 reset oe_n", 64'(per_oe_n), 64'd1);
        chk("R9 reset last_n", 64'(per_last_n), 64'd1);
        chk("R10 reset done", 64'(rsp_done), 64'd0);
        chk("R9 reset be", 64'(per_be), 64'd0);
        // tid cs oe wt sor bem pen hold ten tcnt rk flip err addr be
        txn(1, 0, 0, 0, 1, 1, 1, 0, 0, 0, 0, 4'h0, 0, 32'h0000_1000, 4'hF);   // fastest path
        txn(2, 2, 3, 4, 0, 1, 1, 3, 1, 50, 2, 4'h0, 0, 32'h0000_2004, 4'h3);  // R7 extra cycle
        txn(3, 1, 1, 2, 1, 1, 1, 1, 0, 0, 3, 4'h4, 0, 32'h0000_3008, 4'hC);   // R8 parity bad
        txn(4, 1, 1, 2, 1, 1, 0, 1, 0, 0, 3, 4'h4, 0, 32'h0000_300C, 4'hC);   // R8 parity off
        txn(5, 0, 2, 1, 0, 0, 1, 2, 0, 0, 0, 4'h0, 1, 32'h0000_4010, 4'h5);   // R8 error, R2 off
        txn(6, 1, 1, 0, 1, 1, 1, 2, 1, 8, -1, 4'h0, 0, 32'h0000_5014, 4'h9);  // R6 timeout
        txn(7, 0, 1, 0, 1, 1, 0, 0, 1, 6, 5, 4'h0, 1, 32'h0000_6018, 4'h1);   // R6 tie, ready wins
        txn(8, 0, 1, 0, 0, 1, 0, 1, 1, 6, 5, 4'h0, 0, 32'h0000_601C, 4'h2);   // tie, sor off
        txn(9, 0, 1, 0, 1, 1, 1, 1, 1, 5, 5, 4'h2, 1, 32'h0000_6020, 4'h4);   // ready too late
        txn(10, 3, 2, 2, 0, 1, 1, 0, 0, 3, 40, 4'h0, 0, 32'h0000_7024, 4'h8); // R6 no timeout
        txn(11, 0, 0, 6, 1, 1, 1, 2, 0, 0, 1, 4'h0, 0, 32'h0000_8028, 4'h6);  // R5 early ready
        txn(12, 9, 1, 1, 1, 1, 1, 0, 0, 0, 0, 4'h0, 0, 32'h0000_902C, 4'hA);  // R3 cs never
        txn(13, 0, 0, 0, 1, 1, 1, 1, 1, 0, 0, 4'h0, 1, 32'h0000_A030, 4'hF);  // R6 zero timeout
        txn(14, 2, 0, 3, 0, 1, 1, 5, 1, 30, 4, 4'h1, 1, 32'hFFFF_FFFC, 4'h7); // long hold
        repeat (2) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule